// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It decides when an embedded program or erase operation inside the flash has finished, or has failed. A single-cycle start pulse launches polling. The block then reads the flash status byte through a synchronous request/acknowledge bus. Reads come in back-to-back pairs, and a pair counts as "toggling" when the toggle bit differs between its two reads.

When the toggle bit has stopped, the operation is complete. When the toggle bit is still moving and the timeout bit is clear, the block polls again. When the toggle bit is still moving and the timeout bit is set, one more pair of reads is taken. This extra pair is needed because toggling may stop at the same moment the timeout bit rises. If that recheck still toggles, the operation has failed. The block then writes the reset command byte so that the flash returns to array reads, and reports failure.

A run-time limit on the number of normal checks also ends polling with a failure, followed by the same reset write. The requester sees a busy flag for the whole run and a one-cycle done pulse that carries the pass/fail result.

Top module: `nor_busy_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `bus_req_o` are all low.
- R2: A `start_i` pulse while idle makes `busy_o` go high on the next cycle and begins a read (`bus_req_o`=1, `bus_we_o`=0). A `start_i` pulse while busy has no effect: the run performs exactly the transfers of a single run.
- R3: Each check is two consecutive reads. If bit 6 is equal in both reads, the run ends with `pass_o`=1 and no write is made.
- R4: If bit 6 differs and bit 5 of the second read is 0, the block starts another two-read check.
- R5: If bit 6 differs and bit 5 of the second read is 1, the block takes two more reads. If bit 6 is equal in that recheck, the run ends with `pass_o`=1 and no write is made.
- R6: If the recheck in R5 still shows bit 6 differing, the block makes exactly one write of `RESET_CMD` (0xF0) and then ends the run with `pass_o`=0.
- R7: `max_polls_i` is sampled at start (0 is treated as 1). It bounds the number of normal checks. If the check with that count still toggles with bit 5 at 0, the block makes the R6 reset write and ends with `pass_o`=0. The recheck of R5 is not counted.
- R8: `done_o` is high for exactly one cycle per run, while `busy_o` is still high. `busy_o` is low on the following cycle.
- R9: A transfer completes on each cycle where `bus_req_o` and `bus_ack_i` are both high. Until then, `bus_req_o`, `bus_we_o` and `bus_wdata_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch polling (one-cycle pulse) |
| max_polls_i | input | CNT_W | Maximum number of normal two-read checks |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result, valid with `done_o` (1 = success) |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Transfer is a write |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Transfer accepted this cycle |
| bus_rdata_i | input | DATA_W | Read data, valid with `bus_ack_i` |

## Verification
Two decisions can land on the same status read. The toggle bit may stop on exactly the read where the timeout bit first rises. The timeout bit may also rise on the check that also reaches the poll limit. The bench's flash model sets the read index where toggling stops and the read index where bit 5 rises independently of each other. Directed cases align the two indices, and random cases sweep them against small limits. A reference function replays the polling rules on the same byte sequence and predicts the result, the read count and whether the reset write appears. Each run is judged against that prediction.

// File: rtl/poller_pkg.sv
package poller_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_RCK_A,
      ST_RCK_B,
      ST_RST_WR,
      ST_DONE
   } poll_state_e;

   typedef enum logic [1:0] {
      BUS_NONE,
      BUS_READ,
      BUS_WRITE
   } bus_op_e;
endpackage

// File: rtl/poll_bus_port.sv
module poll_bus_port #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  poller_pkg::bus_op_e  op_i,
   input  logic                 cap_first_i,
   input  logic                 bus_ack_i,
   input  logic [DATA_W-1:0]    bus_rdata_i,
   output logic                 bus_req_o,
   output logic                 bus_we_o,
   output logic [DATA_W-1:0]    bus_wdata_o,
   output logic                 xfer_o,
   output logic [DATA_W-1:0]    first_q_o
);
   import poller_pkg::*;

   assign bus_req_o   = (op_i != BUS_NONE);
   assign bus_we_o    = (op_i == BUS_WRITE);
   assign bus_wdata_o = (op_i == BUS_WRITE) ? RESET_CMD : '0;
   assign xfer_o      = bus_req_o & bus_ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         first_q_o <= '0;
      else if (cap_first_i && xfer_o)
         first_q_o <= bus_rdata_i;
   end
endmodule

// File: rtl/toggle_eval.sv
module toggle_eval #(
   parameter int DATA_W     = 8,
   parameter int TOGGLE_BIT = 6,
   parameter int FAIL_BIT   = 5
) (
   input  logic [DATA_W-1:0] first_i,
   input  logic [DATA_W-1:0] second_i,
   output logic              toggling_o,
   output logic              timeout_o
);
   assign toggling_o = first_i[TOGGLE_BIT] ^ second_i[TOGGLE_BIT];
   assign timeout_o  = second_i[FAIL_BIT];
endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             step_i,
   output logic             at_limit_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W:0]   next_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (load_i) begin
         cnt_q <= '0;
         lim_q <= (limit_i == '0) ? CNT_W'(1) : limit_i;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign next_cnt   = {1'b0, cnt_q} + 1'b1;
   assign at_limit_o = (next_cnt >= {1'b0, lim_q});
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 xfer_i,
   input  logic                 toggling_i,
   input  logic                 timeout_i,
   input  logic                 at_limit_i,
   output poller_pkg::bus_op_e  op_o,
   output logic                 cap_first_o,
   output logic                 load_o,
   output logic                 step_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 pass_o
);
   import poller_pkg::*;

   poll_state_e state_q, state_d;
   logic        pass_q, pass_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pass_q  <= pass_d;
      end
   end

   always_comb begin
      state_d     = state_q;
      pass_d      = pass_q;
      op_o        = BUS_NONE;
      cap_first_o = 1'b0;
      load_o      = 1'b0;
      step_o      = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               pass_d  = 1'b0;
               state_d = ST_RD_A;
            end
         end
         ST_RD_A: begin
            op_o        = BUS_READ;
            cap_first_o = 1'b1;
            if (xfer_i) state_d = ST_RD_B;
         end
         ST_RD_B: begin
            op_o = BUS_READ;
            if (xfer_i) begin
               if (!toggling_i) begin
                  pass_d  = 1'b1;
                  state_d = ST_DONE;
               end else if (timeout_i) begin
                  state_d = ST_RCK_A;
               end else if (at_limit_i) begin
                  pass_d  = 1'b0;
                  state_d = ST_RST_WR;
               end else begin
                  step_o  = 1'b1;
                  state_d = ST_RD_A;
               end
            end
         end
         ST_RCK_A: begin
            op_o        = BUS_READ;
            cap_first_o = 1'b1;
            if (xfer_i) state_d = ST_RCK_B;
         end
         ST_RCK_B: begin
            op_o = BUS_READ;
            if (xfer_i) begin
               pass_d  = !toggling_i;
               state_d = toggling_i ? ST_RST_WR : ST_DONE;
            end
         end
         ST_RST_WR: begin
            op_o = BUS_WRITE;
            if (xfer_i) state_d = ST_DONE;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_DONE);
   assign pass_o = pass_q;
endmodule

// File: rtl/nor_busy_poller.sv
module nor_busy_poller #(
   parameter int DATA_W     = 8,
   parameter int TOGGLE_BIT = 6,
   parameter int FAIL_BIT   = 5,
   parameter int CNT_W      = 16,
   parameter bit LIMIT_EN   = 1'b1,
   parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  max_polls_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_rdata_i
);
   import poller_pkg::*;

   if (TOGGLE_BIT >= DATA_W || FAIL_BIT >= DATA_W) begin : g_bad_bit
      $error("status bit index outside data width");
   end
   if (TOGGLE_BIT == FAIL_BIT) begin : g_bad_same
      $error("toggle and timeout bits must differ");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   bus_op_e           op;
   logic              cap_first, load, step, xfer;
   logic              toggling, timeout, at_limit;
   logic [DATA_W-1:0] first_q;

   poll_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .xfer_i      (xfer),
      .toggling_i  (toggling),
      .timeout_i   (timeout),
      .at_limit_i  (at_limit),
      .op_o        (op),
      .cap_first_o (cap_first),
      .load_o      (load),
      .step_o      (step),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .pass_o      (pass_o)
   );

   poll_bus_port #(.DATA_W(DATA_W), .RESET_CMD(RESET_CMD)) u_bus (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op),
      .cap_first_i (cap_first),
      .bus_ack_i   (bus_ack_i),
      .bus_rdata_i (bus_rdata_i),
      .bus_req_o   (bus_req_o),
      .bus_we_o    (bus_we_o),
      .bus_wdata_o (bus_wdata_o),
      .xfer_o      (xfer),
      .first_q_o   (first_q)
   );

   toggle_eval #(.DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT), .FAIL_BIT(FAIL_BIT)) u_eval (
      .first_i    (first_q),
      .second_i   (bus_rdata_i),
      .toggling_o (toggling),
      .timeout_o  (timeout)
   );

   if (LIMIT_EN) begin : g_limit
      poll_limit #(.CNT_W(CNT_W)) u_limit (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (load),
         .limit_i    (max_polls_i),
         .step_i     (step),
         .at_limit_o (at_limit)
      );
   end else begin : g_nolimit
      assign at_limit = 1'b0;
   end
endmodule

// File: rtl/poller_chk.sv
module poller_chk #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              bus_req_o,
   input logic              bus_we_o,
   input logic [DATA_W-1:0] bus_wdata_o,
   input logic              bus_ack_i
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bus_req_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R8
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_wdata_o)));

   // R6
   reset_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_we_o) |-> (bus_wdata_o == RESET_CMD));

   // R8
   no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !bus_req_o);
endmodule

bind nor_busy_poller poller_chk #(.DATA_W(DATA_W), .RESET_CMD(RESET_CMD)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .bus_req_o   (bus_req_o),
   .bus_we_o    (bus_we_o),
   .bus_wdata_o (bus_wdata_o),
   .bus_ack_i   (bus_ack_i)
);

// File: tb/nor_busy_poller_tb.sv
module nor_busy_poller_tb;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [CNT_W-1:0] max_polls_i = '0;
   logic             busy_o, done_o, pass_o;
   logic             bus_req_o, bus_we_o;
   logic [7:0]       bus_wdata_o;
   logic             bus_ack_i = 1'b0;
   logic [7:0]       bus_rdata_i = '0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // flash model settings: toggling stops at read index stop_at, bit 5 rises at read index tmo_at
   int stop_at = 1;
   int tmo_at  = 1000;
   int rd_cnt  = 0;
   int wr_cnt  = 0;
   int wait_cnt = 0;
   logic [7:0] last_wdata = '0;

   always #5 clk = ~clk;

   nor_busy_poller #(.CNT_W(CNT_W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .max_polls_i (max_polls_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .pass_o      (pass_o),
      .bus_req_o   (bus_req_o),
      .bus_we_o    (bus_we_o),
      .bus_wdata_o (bus_wdata_o),
      .bus_ack_i   (bus_ack_i),
      .bus_rdata_i (bus_rdata_i)
   );

   function automatic logic [7:0] stat_byte(input int i, input int s, input int t);
      logic [7:0] v;
      logic       b6;
      b6 = (i < s) ? 1'(i & 1) : 1'((s - 1) & 1);
      v = 8'((i * 37) & 8'h9F);
      v[6] = b6;
      v[5] = (i >= t);
      return v;
   endfunction

   function automatic void ref_run(input int s, input int t, input int mx,
                                   output bit pass, output int nrd, output int nwr);
      int idx, cnt, lim;
      logic [7:0] a, b;
      idx = 0; cnt = 0; pass = 1'b0; nwr = 0;
      lim = (mx == 0) ? 1 : mx;
      for (int it = 0; it < 2000; it++) begin
         a = stat_byte(idx, s, t);
         b = stat_byte(idx + 1, s, t);
         idx += 2;
         if (a[6] == b[6]) begin pass = 1'b1; break; end
         if (b[5]) begin
            a = stat_byte(idx, s, t);
            b = stat_byte(idx + 1, s, t);
            idx += 2;
            pass = (a[6] == b[6]);
            nwr = pass ? 0 : 1;
            break;
         end
         if (cnt + 1 >= lim) begin pass = 1'b0; nwr = 1; break; end
         cnt++;
      end
      nrd = idx;
   endfunction

   // bus responder: random wait, one-cycle ack
   always @(negedge clk) begin
      cycles++;
      if (!rst_n) begin
         bus_ack_i = 1'b0;
      end else if (bus_ack_i) begin
         bus_ack_i = 1'b0;
      end else if (bus_req_o) begin
         if (wait_cnt == 0) begin
            bus_ack_i = 1'b1;
            if (bus_we_o) begin
               wr_cnt++;
               last_wdata = bus_wdata_o;
            end else begin
               bus_rdata_i = stat_byte(rd_cnt, stop_at, tmo_at);
               rd_cnt++;
            end
            wait_cnt = $urandom_range(0, 2);
         end else begin
            wait_cnt--;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic run_case(input int s, input int t, input int mx, input bit restart);
      bit exp_pass;
      int exp_rd, exp_wr, guard;
      bit seen;
      ref_run(s, t, mx, exp_pass, exp_rd, exp_wr);
      stop_at = s; tmo_at = t;
      rd_cnt = 0; wr_cnt = 0; last_wdata = '0;
      max_polls_i = CNT_W'(mx);
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2: busy one cycle after start
      check(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
      seen = 1'b0;
      guard = 0;
      while (!seen && guard < 5000) begin
         if (done_o === 1'b1) begin
            seen = 1'b1;
         end else begin
            if (restart && guard == 3) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            guard++;
         end
      end
      check(seen, "R8 done seen", int'(seen), 1);
      check(pass_o === exp_pass, "R3/R5/R6/R7 pass flag", int'(pass_o), int'(exp_pass));
      check(rd_cnt == exp_rd, "R2/R4/R5/R9 read count", rd_cnt, exp_rd);
      check(wr_cnt == exp_wr, "R3/R6/R7 write count", wr_cnt, exp_wr);
      if (exp_wr != 0)
         check(last_wdata == 8'hF0, "R6 reset data", int'(last_wdata), 'hF0);
      @(negedge clk);
      check(done_o === 1'b0, "R8 done one cycle", int'(done_o), 0);
      check(busy_o === 1'b0, "R8 busy drops", int'(busy_o), 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
      check(done_o === 1'b0, "R1 done", int'(done_o), 0);
      check(bus_req_o === 1'b0, "R1 req", int'(bus_req_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(bus_req_o === 1'b0, "R1 req idle", int'(bus_req_o), 0);

      // R3: already finished on first pair
      run_case(1, 1000, 8, 1'b0);
      // R4: several normal checks then stop
      run_case(7, 1000, 8, 1'b0);
      // R5: toggling stops on the read where bit 5 rises
      run_case(2, 1, 8, 1'b0);
      run_case(4, 3, 8, 1'b0);
      // R6: recheck still toggling
      run_case(100, 1, 8, 1'b0);
      run_case(100, 5, 8, 1'b0);
      // R7: limit reached, including limit 0 treated as 1
      run_case(1000, 1000, 3, 1'b0);
      run_case(1000, 1000, 0, 1'b0);
      // R7 with bit 5 rising on the limit check: recheck path wins
      run_case(1000, 5, 3, 1'b0);
      // R2: start while busy ignored
      run_case(9, 1000, 8, 1'b1);

      for (int n = 0; n < 40; n++) begin
         run_case($urandom_range(1, 20), $urandom_range(1, 30), $urandom_range(0, 8),
                  1'($urandom_range(0, 1)));
      end
      finish_run();
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
   end
endmodule